// File: doc/BRIEF.md
# Instruction Cycle Clock and Halt Controller

This block sits between a fast input clock and a small processor core. It turns the input clock into a one-clock-wide enable that fires once per instruction cycle. It also produces a square sync wave for the serial clock pin. The divide ratio follows two static option inputs. One selects the oscillator source (crystal, external clock or RC). The other selects a ratio of 16, 8 or 4. An RC source always divides by 4.

The block owns the halt flip-flop and drives its value onto a bidirectional halt pin. A halt strobe from the instruction decoder sets the flip-flop. In the single-pin source modes, an outside agent can also pull the pin high to stop the chip, or pull it low to let it continue. In crystal mode the pin is only an indicator, and only a reset ends a halt.

The reset side merges two sources into one registered reset-active flag, which tells the core to clear its architectural registers. The first source is an active-low external reset that counts only when it has been low for long enough. The second is a power-on hold that can be switched off. Reset always wins over halt.

Top module: `cyc_clk_halt_ctrl`

## Requirements
- R1: With `osc_mode` 0 (crystal), 1 or 3 (external), `div_sel` 0 or 3 gives an instruction period of DIV_MAX input clocks, 1 gives DIV_MAX/2 and 2 gives DIV_MAX/4. `cyc_en` is a single-clock pulse once per period.
- R2: With `osc_mode` 2 (RC), the period is DIV_MAX/4 clocks whatever `div_sel` holds.
- R3: When `halt_strobe` is sampled high, `halt_pin_out` goes high on the next clock. From the clock after that, neither `cyc_en` nor `sync_out` is asserted while halted.
- R4: In modes 1, 2 and 3, a pin level that differs from the block's own drive takes effect on the third rising edge after the pin changes (two synchronizer stages plus one register). A high level halts the block and a low level continues it.
- R5: In mode 0, the pin level is ignored in both directions. A halt is left only through reset.
- R6: The divide counter holds while halted and restarts at zero on continue. The first `cyc_en` after continue comes exactly one period after `halt_pin_out` falls.
- R7: If a continue request and a halt strobe occur on the same clock, continue wins.
- R8: An external reset is accepted only when the synchronized `ext_rst_n` has been low for RST_MIN_CYCLES periods' worth of clocks. One clock less is ignored. Once accepted, `rst_act` stays high until the pin returns high.
- R9: After `rst` with `por_hold_en`=1, `rst_act` stays high for POR_CYCLES periods plus one clock. With `por_hold_en`=0 it stays high for one clock only.
- R10: `rst_act` clears the halt flip-flop in every mode and blocks `halt_strobe`.
- R11: `cyc_en` and `sync_out` stay low while reset is active. The first `cyc_en` comes exactly one period after `rst_act` falls.
- R12: While running, `sync_out` is high for half of every instruction period and rises once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high power-up event |
| osc_mode | input | 2 | Source option: 0 crystal, 1/3 external, 2 RC (static) |
| div_sel | input | 2 | Ratio option: 0/3 full, 1 half, 2 quarter of DIV_MAX (static) |
| por_hold_en | input | 1 | Enables the power-on hold |
| ext_rst_n | input | 1 | Asynchronous active-low external reset |
| halt_strobe | input | 1 | Halt instruction strobe from the decoder |
| halt_pin_in | input | 1 | Level read back from the halt pin pad |
| cyc_en | output | 1 | One-clock instruction cycle enable |
| sync_out | output | 1 | Half-duty sync wave for the serial clock |
| halt_pin_out | output | 1 | Drive value of the halt pin (halt flip-flop) |
| rst_act | output | 1 | Core initialization request |

## Verification
The bench builds the block with DIV_MAX=16, RST_MIN_CYCLES=3 and two synchronizer stages, so periods of 16, 8 and 4 clocks are all measured. It lowers POR_CYCLES to 5. The full power-on hold then lasts 81 clocks instead of tens of thousands, and the exact hold length and the 47/48-clock external reset boundary both fit in a short run. The pad is modelled as the block's own drive unless the bench forces it. This lets the pin halt, pin continue, same-cycle conflict and crystal-mode immunity be timed to the exact edge.

// File: rtl/cyc_halt_pkg.sv
package cyc_halt_pkg;

  typedef enum logic [1:0] {
    OSC_XTAL    = 2'd0,
    OSC_EXT     = 2'd1,
    OSC_RC      = 2'd2,
    OSC_EXT_ALT = 2'd3
  } osc_mode_e;

  // Right shift applied to DIV_MAX: 0 -> full, 1 -> half, 2 -> quarter.
  function automatic logic [1:0] ratio_shift(input logic [1:0] mode,
                                             input logic [1:0] sel);
    if (osc_mode_e'(mode) == OSC_RC) return 2'd2;
    case (sel)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/cyc_sync.sv
module cyc_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= INIT;
        else     sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{INIT}};
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cyc_divider.sv
module cyc_divider #(
  parameter int DIV_MAX = 16,
  localparam int CW = $clog2(DIV_MAX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic [CW-1:0] div_m1,
  output logic          cyc_en,
  output logic          sync_out
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;

  assign half_m1 = {1'b0, div_m1[CW-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (run)      cnt <= (cnt == div_m1) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_en   <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      cyc_en   <= run && (cnt == div_m1);
      sync_out <= run && (cnt <= half_m1);
    end
  end
endmodule

// File: rtl/cyc_reset_seq.sv
module cyc_reset_seq #(
  parameter int DIV_MAX        = 16,
  parameter int POR_CYCLES     = 2500,
  parameter int RST_MIN_CYCLES = 3,
  localparam int POR_MAX = POR_CYCLES * DIV_MAX,
  localparam int EXT_MAX = RST_MIN_CYCLES * DIV_MAX,
  localparam int PW      = $clog2(POR_MAX + 1),
  localparam int EW      = $clog2(EXT_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_hold_en,
  input  logic       ext_low,
  input  logic [1:0] shift,
  output logic       rst_act
);
  logic [PW-1:0] por_cnt, por_lim;
  logic [EW-1:0] low_cnt, ext_lim;
  logic          por_busy;
  logic          ext_ok;

  assign por_lim = PW'(POR_MAX >> shift);
  assign ext_lim = EW'(EXT_MAX >> shift);
  assign ext_ok  = (low_cnt == ext_lim);

  // Power-on hold counted in input clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      por_busy <= por_hold_en;
      por_cnt  <= '0;
    end else if (por_busy) begin
      if (por_cnt == por_lim - 1'b1) por_busy <= 1'b0;
      else                           por_cnt  <= por_cnt + 1'b1;
    end
  end

  // Low-width qualifier for the external pin, saturating at the limit.
  always_ff @(posedge clk) begin
    if (rst || !ext_low)        low_cnt <= '0;
    else if (low_cnt != ext_lim) low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rst_act <= 1'b1;
    else     rst_act <= por_busy || ext_ok;
  end
endmodule

// File: rtl/cyc_halt_fsm.sv
module cyc_halt_fsm
  import cyc_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_act,
  input  logic [1:0] osc_mode,
  input  logic       halt_strobe,
  input  logic       pad_s,
  input  logic       drive_dly,
  output logic       halted,
  output logic       cont
);
  logic single_pin;
  logic pin_set;

  assign single_pin = (osc_mode_e'(osc_mode) != OSC_XTAL);
  // The pad is compared with the own drive delayed by the same stages.
  assign cont    = single_pin && halted  && !pad_s && drive_dly;
  assign pin_set = single_pin && !halted && pad_s  && !drive_dly;

  always_ff @(posedge clk) begin
    if (rst || rst_act)              halted <= 1'b0;
    else if (cont)                   halted <= 1'b0;
    else if (halt_strobe || pin_set) halted <= 1'b1;
  end
endmodule

// File: rtl/cyc_clk_halt_ctrl.sv
module cyc_clk_halt_ctrl
  import cyc_halt_pkg::*;
#(
  parameter int DIV_MAX        = 16,
  parameter int POR_CYCLES     = 2500,
  parameter int RST_MIN_CYCLES = 3,
  parameter int SYNC_STAGES    = 2,
  localparam int CW = $clog2(DIV_MAX)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] osc_mode,
  input  logic [1:0] div_sel,
  input  logic       por_hold_en,
  input  logic       ext_rst_n,
  input  logic       halt_strobe,
  input  logic       halt_pin_in,
  output logic       cyc_en,
  output logic       sync_out,
  output logic       halt_pin_out,
  output logic       rst_act
);
  logic          ext_rst_s, pad_s, drive_dly;
  logic          halted, cont, run;
  logic [1:0]    shift;
  logic [CW-1:0] div_m1;

  assign shift  = ratio_shift(osc_mode, div_sel);
  assign div_m1 = CW'((DIV_MAX >> shift) - 1);
  assign run    = !halted && !rst_act;

  cyc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_rst_sync (
    .clk(clk), .rst(rst), .d(ext_rst_n), .q(ext_rst_s));

  cyc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_pad_sync (
    .clk(clk), .rst(rst), .d(halt_pin_in), .q(pad_s));

  cyc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_drv_dly (
    .clk(clk), .rst(rst), .d(halted), .q(drive_dly));

  cyc_reset_seq #(
    .DIV_MAX(DIV_MAX), .POR_CYCLES(POR_CYCLES), .RST_MIN_CYCLES(RST_MIN_CYCLES)
  ) u_rst_seq (
    .clk(clk), .rst(rst), .por_hold_en(por_hold_en), .ext_low(!ext_rst_s),
    .shift(shift), .rst_act(rst_act));

  cyc_halt_fsm u_halt (
    .clk(clk), .rst(rst), .rst_act(rst_act), .osc_mode(osc_mode),
    .halt_strobe(halt_strobe), .pad_s(pad_s), .drive_dly(drive_dly),
    .halted(halted), .cont(cont));

  cyc_divider #(.DIV_MAX(DIV_MAX)) u_div (
    .clk(clk), .rst(rst), .clear(rst_act || cont), .run(run),
    .div_m1(div_m1), .cyc_en(cyc_en), .sync_out(sync_out));

  assign halt_pin_out = halted;
endmodule

// File: rtl/cyc_clk_halt_chk.sv
module cyc_clk_halt_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] osc_mode,
  input logic       cyc_en,
  input logic       sync_out,
  input logic       halt_pin_out,
  input logic       rst_act
);
  p_en_single_r1: assert property (@(posedge clk) disable iff (rst)
    cyc_en |=> !cyc_en);

  p_halt_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    (halt_pin_out && $past(halt_pin_out)) |-> (!cyc_en && !sync_out));

  p_xtal_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(halt_pin_out) && !$past(rst_act) && !$past(rst) &&
     $past(osc_mode) == 2'd0 && osc_mode == 2'd0) |-> halt_pin_out);

  p_resume_gap_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(halt_pin_out) && !halt_pin_out) |-> !cyc_en);

  p_rst_clears_halt_r10: assert property (@(posedge clk) disable iff (rst)
    rst_act |=> !halt_pin_out);

  p_rst_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (rst_act && $past(rst_act)) |-> (!cyc_en && !sync_out));
endmodule

bind cyc_clk_halt_ctrl cyc_clk_halt_chk u_chk (
  .clk(clk), .rst(rst), .osc_mode(osc_mode), .cyc_en(cyc_en),
  .sync_out(sync_out), .halt_pin_out(halt_pin_out), .rst_act(rst_act));

// File: tb/cyc_clk_halt_ctrl_bench.sv
module cyc_clk_halt_ctrl_bench;
  localparam int DIV_MAX = 16;
  localparam int POR_CYC = 5;
  localparam int RST_MIN = 3;
  localparam int SS      = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] osc_mode = 2'd1, div_sel = 2'd0;
  logic por_hold_en = 1'b0, ext_rst_n = 1'b1, halt_strobe = 1'b0;
  logic force_hi = 1'b0, force_lo = 1'b0;
  logic halt_pin_in, cyc_en, sync_out, halt_pin_out, rst_act;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign halt_pin_in = force_hi ? 1'b1 : (force_lo ? 1'b0 : halt_pin_out);

  cyc_clk_halt_ctrl #(.DIV_MAX(DIV_MAX), .POR_CYCLES(POR_CYC),
    .RST_MIN_CYCLES(RST_MIN), .SYNC_STAGES(SS)) u_cyc_clk_halt_ctrl (
    .clk(clk), .rst(rst), .osc_mode(osc_mode), .div_sel(div_sel),
    .por_hold_en(por_hold_en), .ext_rst_n(ext_rst_n), .halt_strobe(halt_strobe),
    .halt_pin_in(halt_pin_in), .cyc_en(cyc_en), .sync_out(sync_out),
    .halt_pin_out(halt_pin_out), .rst_act(rst_act));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse rst with given options; returns clocks with rst_act high after it.
  task automatic do_init(input logic [1:0] m, input logic [1:0] s, input bit hold,
                         output int held);
    @(negedge clk);
    osc_mode = m; div_sel = s; por_hold_en = hold; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    held = 0;
    while (rst_act && held < 5000) begin held++; @(negedge clk); end
  endtask

  task automatic count_to_en(output int n);
    n = 0;
    while (!cyc_en && n < 500) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(rst_act == 1'b1, "R11 rst_act in reset", rst_act, 1);
    check(cyc_en == 1'b0 && sync_out == 1'b0, "R11 quiet in reset", cyc_en, 0);
    check(halt_pin_out == 1'b0, "R10 halt clear in reset", halt_pin_out, 0);
  endtask

  task automatic t_div(input logic [1:0] m, input logic [1:0] s, input int exp);
    int held, n, hi, rises;
    logic prev;
    do_init(m, s, 1'b0, held);
    count_to_en(n);
    check(n == exp, "R11 first enable after reset", n, exp);
    @(negedge clk);
    count_to_en(n);
    check(n + 1 == exp, (m == 2'd2) ? "R2 RC period" : "R1 period", n + 1, exp);
    hi = 0; rises = 0; prev = sync_out;
    for (int k = 0; k < 2 * exp; k++) begin
      @(negedge clk);
      if (sync_out) hi++;
      if (sync_out && !prev) rises++;
      prev = sync_out;
    end
    check(hi == exp && rises == 2, "R12 sync duty", hi, exp);
  endtask

  task automatic t_por;
    int held;
    do_init(2'd0, 2'd0, 1'b1, held);
    check(held == POR_CYC * DIV_MAX + 1, "R9 hold full ratio", held, POR_CYC * DIV_MAX + 1);
    do_init(2'd1, 2'd2, 1'b1, held);
    check(held == POR_CYC * 4 + 1, "R9 hold quarter ratio", held, POR_CYC * 4 + 1);
    do_init(2'd1, 2'd0, 1'b0, held);
    check(held == 1, "R9 hold disabled", held, 1);
  endtask

  task automatic strobe_halt;
    halt_strobe = 1'b1;
    @(negedge clk);
    halt_strobe = 1'b0;
  endtask

  task automatic t_halt_and_pin;
    int held, n, seen;
    do_init(2'd1, 2'd2, 1'b0, held);
    repeat (6) @(negedge clk);
    strobe_halt();
    check(halt_pin_out == 1'b1, "R3 halt next clock", halt_pin_out, 1);
    @(negedge clk);
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      if (cyc_en || sync_out) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R3 frozen while halted", seen, 0);
    force_lo = 1'b1;
    repeat (2) @(negedge clk);
    check(halt_pin_out == 1'b1, "R4 continue not early", halt_pin_out, 1);
    @(negedge clk);
    check(halt_pin_out == 1'b0, "R4 continue on third edge", halt_pin_out, 0);
    force_lo = 1'b0;
    count_to_en(n);
    check(n == 4, "R6 first enable after continue", n, 4);
    repeat (3) @(negedge clk);
    force_hi = 1'b1;
    repeat (2) @(negedge clk);
    check(halt_pin_out == 1'b0, "R4 pin halt not early", halt_pin_out, 0);
    @(negedge clk);
    check(halt_pin_out == 1'b1, "R4 pin halt on third edge", halt_pin_out, 1);
    force_hi = 1'b0;
    repeat (5) @(negedge clk);
    check(halt_pin_out == 1'b1, "R4 halt kept after release", halt_pin_out, 1);
    // R7: strobe placed on the very edge where continue is taken.
    force_lo = 1'b1;
    repeat (2) @(negedge clk);
    halt_strobe = 1'b1;
    @(negedge clk);
    halt_strobe = 1'b0;
    check(halt_pin_out == 1'b0, "R7 continue wins", halt_pin_out, 0);
    force_lo = 1'b0;
    repeat (4) @(negedge clk);
    check(halt_pin_out == 1'b0, "R7 stays running", halt_pin_out, 0);
  endtask

  task automatic t_xtal;
    int held, seen;
    do_init(2'd0, 2'd1, 1'b0, held);
    force_hi = 1'b1;
    seen = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (cyc_en) seen++; end
    force_hi = 1'b0;
    check(halt_pin_out == 1'b0 && seen > 0, "R5 pin high ignored", halt_pin_out, 0);
    strobe_halt();
    force_lo = 1'b1;
    repeat (12) @(negedge clk);
    force_lo = 1'b0;
    repeat (6) @(negedge clk);
    check(halt_pin_out == 1'b1, "R5 pin low ignored", halt_pin_out, 1);
    ext_rst_n = 1'b0;
    repeat (RST_MIN * 8 + SS + 4) @(negedge clk);
    check(rst_act == 1'b1 && halt_pin_out == 1'b0, "R10 reset ends crystal halt",
          halt_pin_out, 0);
    ext_rst_n = 1'b1;
    repeat (SS + 3) @(negedge clk);
  endtask

  task automatic t_ext_rst;
    int held, seen;
    do_init(2'd1, 2'd0, 1'b0, held);
    ext_rst_n = 1'b0;
    seen = 0;
    for (int k = 0; k < RST_MIN * DIV_MAX - 1; k++) begin
      @(negedge clk); if (rst_act) seen++;
    end
    ext_rst_n = 1'b1;
    for (int k = 0; k < SS + 6; k++) begin @(negedge clk); if (rst_act) seen++; end
    check(seen == 0, "R8 short low ignored", seen, 0);
    ext_rst_n = 1'b0;
    for (int k = 0; k < RST_MIN * DIV_MAX; k++) begin
      @(negedge clk); if (rst_act) seen++;
    end
    ext_rst_n = 1'b1;
    for (int k = 0; k < SS + 6; k++) begin @(negedge clk); if (rst_act) seen++; end
    check(seen > 0, "R8 exact width accepted", seen, 1);
    ext_rst_n = 1'b0;
    halt_strobe = 1'b1;
    repeat (RST_MIN * DIV_MAX + 20) @(negedge clk);
    check(rst_act == 1'b1, "R8 held while low", rst_act, 1);
    check(halt_pin_out == 1'b0, "R10 strobe blocked in reset", halt_pin_out, 0);
    halt_strobe = 1'b0;
    @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (SS + 3) @(negedge clk);
    check(rst_act == 1'b0 && halt_pin_out == 1'b0, "R8 released", rst_act, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_div(2'd0, 2'd0, 16);
    t_div(2'd1, 2'd1, 8);
    t_div(2'd3, 2'd2, 4);
    t_div(2'd2, 2'd0, 4);
    t_por();
    t_halt_and_pin();
    t_xtal();
    t_ext_rst();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule